// File: doc/BRIEF.md
# Prescaled Timer/Counter with Compare-Clear and PWM

This block is a 16-bit timer/counter that moves one step on every clock where an external prescaler tick is high. With PWM off it either runs freely or returns to zero after it reaches the value held in compare register A. A 2-bit resolution selector enables PWM with an 8-, 9- or 10-bit period. In PWM mode the clear-on-compare control bit takes a different meaning: when clear, the counter counts up to the period's top and back down; when set, it counts up to the top and wraps to zero.

The block drives three outputs. The first is the counter value. The second is a one-clock compare-match pulse, high on any tick at which the counter equals the effective compare value. The third is a PWM pin, high while the counter is below that compare value. The register bus decode, the interrupt logic and the prescaler divider are outside the block; the prescaler reaches it only as the tick input.

Top module: `pwm_timer16`

## Requirements
- R1: `pwm_sel` encodes the mode: 2'b00 disables PWM, 2'b01 selects an 8-bit PWM with TOP = 16'h00FF, 2'b10 a 9-bit PWM with TOP = 16'h01FF, and 2'b11 a 10-bit PWM with TOP = 16'h03FF.
- R2: The counter changes only on clocks where `tick` is 1, and holds its value on all other clocks. A synchronous `rst` clears it to 16'h0000 and sets the count direction to upward.
- R3: With PWM off and `clr_on_match` = 0, each tick adds one to the counter, and 16'hFFFF wraps to 16'h0000. A compare match does not disturb counting.
- R4: With PWM off and `clr_on_match` = 1, a tick that finds the counter equal to `cmp_a` loads 0, so the counter runs C-1, C, 0, 1. Between ticks, every value, C included, is held.
- R5: In PWM mode with `clr_on_match` = 0, the counter runs up to TOP and then back down: ..., TOP-1, TOP, TOP-1, ..., 1, 0, 1, .... A tick in any other mode makes the next up/down run start upward.
- R6: In PWM mode with `clr_on_match` = 1, a tick at count TOP loads 0. All other ticks add one.
- R7: `match_pulse` is high during exactly those clocks where `tick` = 1 and the counter equals the effective compare value. That value is `cmp_a` with PWM off and `cmp_a & TOP` in PWM mode.
- R8: `pwm_out` is 1 while PWM is on and the counter is below `cmp_a & TOP`. It is 0 at all other times, and always 0 with PWM off.
- R9: If a PWM mode is entered with the counter above TOP, wrap mode loads 0 on the next tick, and up/down mode counts down by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler enable; the counter steps on clocks where it is high |
| pwm_sel | input | 2 | PWM resolution select (00 off, 01 8-bit, 10 9-bit, 11 10-bit) |
| clr_on_match | input | 1 | Clear-on-compare with PWM off; wrap-at-TOP instead of up/down in PWM mode |
| cmp_a | input | 16 | Compare register A value |
| count | output | 16 | Current counter value |
| match_pulse | output | 1 | One-clock pulse on a tick at which the counter equals the effective compare value |
| pwm_out | output | 1 | PWM pin |

## Verification
On every cycle, the assertions check the following. The counter holds between ticks and clears after reset. It adds exactly one per tick in free-running mode. It reaches zero after a tick at the compare value in clear mode, and after a tick at TOP in wrap mode. The match pulse never appears without a tick, and the PWM pin stays low with PWM off.

Only the bench's scenarios can show the rest. These are the full up/down turn-around at TOP and at zero, the peak value that each resolution reaches, the masking of `cmp_a` to the PWM width, the behaviour on entering a PWM mode with the counter above TOP, the 16-bit wrap, and the divide-by-8 hold of C and of the following 0.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int TMR_W    = 16;
    localparam int BASE_RES = 8;
    localparam int SEL_W    = 2;

    typedef logic [TMR_W-1:0] tval_t;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_CLEAR    = 2'd1,
        MODE_PWM_UPDN = 2'd2,
        MODE_PWM_WRAP = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        cnt_mode_e mode;
        logic      pwm_on;
        tval_t     top;
        tval_t     cmp_eff;
    } timer_cfg_t;

    typedef struct packed {
        tval_t value;
        logic  down;
    } cnt_state_t;

    // Period top for a given resolution select; all ones when PWM is off.
    function automatic tval_t top_for(input logic [SEL_W-1:0] sel);
        tval_t t;
        if (sel == '0)
            t = '1;
        else
            t = tval_t'((32'd1 << (BASE_RES - 1 + int'(sel))) - 32'd1);
        return t;
    endfunction

endpackage

// File: rtl/timer_mode_dec.sv
module timer_mode_dec
    import timer_pkg::*;
(
    input  logic [SEL_W-1:0] pwm_sel,
    input  logic             clr_on_match,
    input  tval_t            cmp_a,
    output timer_cfg_t       cfg
);

    always_comb begin
        cfg.pwm_on  = (pwm_sel != '0);
        cfg.top     = top_for(pwm_sel);
        cfg.cmp_eff = cfg.pwm_on ? (cmp_a & cfg.top) : cmp_a;
        unique case ({cfg.pwm_on, clr_on_match})
            2'b00:   cfg.mode = MODE_NORMAL;
            2'b01:   cfg.mode = MODE_CLEAR;
            2'b10:   cfg.mode = MODE_PWM_UPDN;
            default: cfg.mode = MODE_PWM_WRAP;
        endcase
    end

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  timer_cfg_t cfg,
    output tval_t      count
);

    cnt_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (cfg.mode)
            MODE_NORMAL: begin
                nxt.value = cur.value + tval_t'(1);
                nxt.down  = 1'b0;
            end
            MODE_CLEAR: begin
                nxt.value = (cur.value == cfg.cmp_eff) ? '0 : cur.value + tval_t'(1);
                nxt.down  = 1'b0;
            end
            MODE_PWM_WRAP: begin
                nxt.value = (cur.value >= cfg.top) ? '0 : cur.value + tval_t'(1);
                nxt.down  = 1'b0;
            end
            default: begin
                if (!cur.down) begin
                    if (cur.value >= cfg.top) begin
                        nxt.value = cur.value - tval_t'(1);
                        nxt.down  = 1'b1;
                    end else begin
                        nxt.value = cur.value + tval_t'(1);
                    end
                end else if (cur.value == '0) begin
                    nxt.value = tval_t'(1);
                    nxt.down  = 1'b0;
                end else begin
                    nxt.value = cur.value - tval_t'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.value <= '0;
            cur.down  <= 1'b0;
        end else if (tick) begin
            cur <= nxt;
        end
    end

    assign count = cur.value;

endmodule

// File: rtl/timer_out_stage.sv
module timer_out_stage
    import timer_pkg::*;
(
    input  logic       tick,
    input  timer_cfg_t cfg,
    input  tval_t      count,
    output logic       match_pulse,
    output logic       pwm_out
);

    logic equal_cmp;
    logic below_cmp;

    always_comb begin
        equal_cmp   = (count == cfg.cmp_eff);
        below_cmp   = (count < cfg.cmp_eff);
        match_pulse = tick & equal_cmp;
        pwm_out     = cfg.pwm_on & below_cmp;
    end

endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        pwm_sel,
    input  logic              clr_on_match,
    input  logic [15:0]       cmp_a,
    output logic [15:0]       count,
    output logic              match_pulse,
    output logic              pwm_out
);

    timer_cfg_t cfg;
    tval_t      cnt_q;

    timer_mode_dec u_dec (
        .pwm_sel      (pwm_sel),
        .clr_on_match (clr_on_match),
        .cmp_a        (cmp_a),
        .cfg          (cfg)
    );

    timer_count_core u_core (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cfg   (cfg),
        .count (cnt_q)
    );

    timer_out_stage u_out (
        .tick        (tick),
        .cfg         (cfg),
        .count       (cnt_q),
        .match_pulse (match_pulse),
        .pwm_out     (pwm_out)
    );

    assign count = cnt_q;

endmodule

// File: rtl/timer_chk.sv
module timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic [1:0]  pwm_sel,
    input logic        clr_on_match,
    input logic [15:0] cmp_a,
    input logic [15:0] count,
    input logic        match_pulse,
    input logic        pwm_out
);

    logic [15:0] top_c;
    always_comb begin
        case (pwm_sel)
            2'b01:   top_c = 16'h00FF;
            2'b10:   top_c = 16'h01FF;
            2'b11:   top_c = 16'h03FF;
            default: top_c = 16'hFFFF;
        endcase
    end

    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |=> count == 16'h0000);

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    assert_free_run_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_sel == 2'b00 && !clr_on_match) |=> count == 16'($past(count) + 16'd1));

    assert_ctc_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_sel == 2'b00 && clr_on_match && count == cmp_a) |=> count == 16'h0000);

    assert_wrap_top_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm_sel != 2'b00 && clr_on_match && count == top_c) |=> count == 16'h0000);

    assert_pulse_needs_tick_R7: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> tick);

    assert_pwm_low_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (pwm_sel == 2'b00) |-> !pwm_out);

endmodule

bind pwm_timer16 timer_chk u_chk (.*);

// File: tb/tb_pwm_timer16.sv
module tb_pwm_timer16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  pwm_sel = 2'b00;
    logic        clr_on_match = 1'b0;
    logic [15:0] cmp_a = 16'h0000;
    logic [15:0] count;
    logic        match_pulse;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_cnt = 16'h0000;
    logic        m_dn  = 1'b0;
    logic [15:0] peak  = 16'h0000;

    always #2 clk = ~clk;

    pwm_timer16 dut (
        .clk(clk), .rst(rst), .tick(tick), .pwm_sel(pwm_sel),
        .clr_on_match(clr_on_match), .cmp_a(cmp_a),
        .count(count), .match_pulse(match_pulse), .pwm_out(pwm_out)
    );

    function automatic logic [15:0] b_top(input logic [1:0] s);
        return (s == 2'b00) ? 16'hFFFF : 16'((32'd1 << (7 + int'(s))) - 32'd1);
    endfunction

    function automatic logic [15:0] b_ceff(input logic [1:0] s, input logic [15:0] c);
        return (s == 2'b00) ? c : (c & b_top(s));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        m_cnt = 16'h0000; m_dn = 1'b0; peak = 16'h0000;
    endtask

    task automatic step(input logic t, input string tag);
        logic [15:0] top, ce, nx;
        logic        nd;
        @(negedge clk);
        tick = t;
        #1;
        top = b_top(pwm_sel);
        ce  = b_ceff(pwm_sel, cmp_a);
        check(tag, count, m_cnt);
        check("R7", match_pulse, t && (m_cnt == ce));
        check("R8", pwm_out, (pwm_sel != 2'b00) && (m_cnt < ce));
        if (m_cnt > peak) peak = m_cnt;
        nx = m_cnt; nd = m_dn;
        if (t) begin
            if (pwm_sel == 2'b00) begin
                nd = 1'b0;
                nx = (clr_on_match && m_cnt == cmp_a) ? 16'h0000 : 16'(m_cnt + 16'd1);
            end else if (clr_on_match) begin
                nd = 1'b0;
                nx = (m_cnt >= top) ? 16'h0000 : 16'(m_cnt + 16'd1);
            end else if (!m_dn) begin
                if (m_cnt >= top) begin nx = m_cnt - 16'd1; nd = 1'b1; end
                else nx = m_cnt + 16'd1;
            end else if (m_cnt == 16'h0000) begin
                nx = 16'd1; nd = 1'b0;
            end else begin
                nx = m_cnt - 16'd1;
            end
        end
        @(posedge clk); #1;
        m_cnt = nx; m_dn = nd;
    endtask

    initial begin
        #600000;
        fails++; checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R2: reset state
        @(posedge clk); @(posedge clk); #1;
        check("R2", count, 16'h0000);
        check("R2", match_pulse, 1'b0);
        check("R8", pwm_out, 1'b0);
        rst = 1'b0;

        // R3: free run through a match value, then 16-bit wrap
        do_reset();
        pwm_sel = 2'b00; clr_on_match = 1'b0; cmp_a = 16'd5;
        for (int i = 0; i < 65545; i++) step(1'b1, "R3");

        // R4: clear on compare, every-clock ticks
        do_reset();
        clr_on_match = 1'b1; cmp_a = 16'd6;
        for (int i = 0; i < 24; i++) step(1'b1, "R4");
        // R4/R2: divide-by-8 prescale holds C and the following 0
        do_reset();
        for (int i = 0; i < 96; i++) step((i % 8) == 7, "R4");
        for (int i = 0; i < 40; i++) step((i % 3) == 0, "R2");

        // R5 + R1: up/down for each resolution
        for (int s = 1; s < 4; s++) begin
            do_reset();
            pwm_sel = 2'(s); clr_on_match = 1'b0; cmp_a = 16'hF0A0;
            for (int i = 0; i < 2 * int'(b_top(2'(s))) + 12; i++) step(1'b1, "R5");
            check("R1", peak, b_top(2'(s)));
        end

        // R6 + R1: wrap for each resolution
        for (int s = 1; s < 4; s++) begin
            do_reset();
            pwm_sel = 2'(s); clr_on_match = 1'b1; cmp_a = 16'h1240 + 16'(s);
            for (int i = 0; i < int'(b_top(2'(s))) + 12; i++) step(1'b1, "R6");
            check("R1", peak, b_top(2'(s)));
        end

        // R9: enter PWM above TOP, wrap mode
        do_reset();
        pwm_sel = 2'b00; clr_on_match = 1'b0; cmp_a = 16'hFFFF;
        for (int i = 0; i < 300; i++) step(1'b1, "R3");
        pwm_sel = 2'b01; clr_on_match = 1'b1;
        step(1'b1, "R9");
        step(1'b1, "R9");
        check("R9", count, 16'h0001);

        // R9: enter PWM above TOP, up/down mode
        do_reset();
        pwm_sel = 2'b00; clr_on_match = 1'b0;
        for (int i = 0; i < 300; i++) step(1'b1, "R3");
        pwm_sel = 2'b01; clr_on_match = 1'b0; cmp_a = 16'h0080;
        step(1'b1, "R9");
        step(1'b1, "R9");
        check("R9", count, 16'd298);
        for (int i = 0; i < 40; i++) step(1'b1, "R5");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule